// File: doc/BRIEF.md
# Stack Pointer Delta Tracking Engine

This block sits at the tail of the decode stage and filters the micro-op stream on its way to rename. Micro-ops whose only effect on the stack pointer is an implicit adjustment (push and call move it down, pop and return move it up) are absorbed. A small adder inside the block applies each one to a signed speculative offset held locally, and the micro-op itself is dropped. The out-of-order core never sees those adjustments.

The offset has to reach the renamed architectural stack register before anything depends on the true value. When a micro-op that names the stack pointer explicitly arrives while the offset is non-zero, the block first emits a synchronization micro-op that carries the offset and clears it, and only then lets the explicit micro-op through. A synchronization micro-op is also forced when the next adjustment would push the offset out of its signed range. A pipeline flush discards the offset and any output that has not yet been taken.

The block handles one micro-op per cycle on valid/ready streams at both sides, with a single registered output slot. Inserting a synchronization micro-op costs the upstream side one stalled cycle.

Top module: `stack_delta_engine`

## Requirements
- R1: After reset the output slot is empty (out_valid low), in_ready is high when the block is idle, and the offset is zero, so the first explicit stack micro-op passes with no synchronization micro-op ahead of it.
- R2: Micro-ops of kind code 0, 5, 6 or 7 pass unchanged, in their original order, with kind and payload intact. An accepted micro-op appears at the output one cycle after it is accepted.
- R3: Kind code 1 (push or call, moving down) subtracts 8 from the signed 8-bit offset, and kind code 2 (pop or return, moving up) adds 8. Neither produces any output micro-op.
- R4: A kind code 3 micro-op (explicit stack pointer use) arriving with a non-zero offset is held with in_ready low for one cycle. In that cycle a synchronization micro-op is loaded: kind code 4, payload equal to the offset sign-extended to 16 bits. The offset is cleared, and the explicit micro-op then follows unchanged.
- R5: A kind code 3 micro-op arriving with a zero offset passes with no synchronization micro-op.
- R6: An adjustment that would take the offset below -128 or above 127 first forces a synchronization micro-op carrying the current offset. The adjustment is then applied to the cleared offset.
- R7: While flush is high, in_ready is low. In the next cycle out_valid is low (any pending output is discarded) and the offset is zero.
- R8: While out_valid is high and out_ready is low, the output kind and payload stay stable, and in_ready is low for every input kind except 1 and 2. Adjustments that fit the range are still absorbed in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush: clears the offset and the output slot |
| in_valid | input | 1 | Upstream micro-op valid |
| in_ready | output | 1 | Block accepts the upstream micro-op this cycle |
| in_kind | input | 3 | Micro-op kind: 0/5/6/7 plain, 1 move down, 2 move up, 3 explicit stack use |
| in_payload | input | 16 | Opaque micro-op payload |
| out_valid | output | 1 | Output micro-op valid |
| out_ready | input | 1 | Downstream accepts the output micro-op |
| out_kind | output | 3 | Output kind: input kind passed through, or 4 for synchronization |
| out_payload | output | 16 | Input payload, or the sign-extended offset for a synchronization micro-op |

## Verification
The assertions assume that upstream never presents kind code 4, which is reserved for synchronization micro-ops the block creates itself. They also assume that flush is a plain single-cycle or multi-cycle pulse with no other constraint. The bench draws every input kind from codes 0 to 3 and 5 to 7 only. It holds each micro-op steady until it has been accepted, and raises flush only while the output is back-pressured, so that a discarded synchronization micro-op is never also taken by the downstream side.

// File: rtl/sde_pkg.sv
package sde_pkg;

  typedef enum logic [2:0] {
    KIND_PLAIN    = 3'd0,
    KIND_ADJ_DOWN = 3'd1,
    KIND_ADJ_UP   = 3'd2,
    KIND_SP_USE   = 3'd3,
    KIND_SYNC     = 3'd4
  } uop_kind_e;

  localparam int KIND_W = 3;

  function automatic logic kind_is_adjust(input logic [KIND_W-1:0] k);
    return (k == KIND_ADJ_DOWN) || (k == KIND_ADJ_UP);
  endfunction

  function automatic logic kind_is_sp_use(input logic [KIND_W-1:0] k);
    return k == KIND_SP_USE;
  endfunction

endpackage

// File: rtl/sde_classify.sv
module sde_classify
  import sde_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  output logic              is_adj,
  output logic              adj_down,
  output logic              is_sp_use
);
  always_comb begin
    is_adj    = kind_is_adjust(kind);
    adj_down  = (kind == KIND_ADJ_DOWN);
    is_sp_use = kind_is_sp_use(kind);
  end
endmodule

// File: rtl/sde_delta_unit.sv
module sde_delta_unit #(
  parameter int DELTA_W = 8,
  parameter int STEP    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               apply,
  input  logic               dir_down,
  output logic [DELTA_W-1:0] delta_q,
  output logic               fits
);
  localparam int SUM_W = DELTA_W + 1;

  function automatic logic [SUM_W-1:0] f_sum(input logic [DELTA_W-1:0] d,
                                             input logic down);
    logic [SUM_W-1:0] ext;
    ext = {d[DELTA_W-1], d};
    return down ? ext - SUM_W'(STEP) : ext + SUM_W'(STEP);
  endfunction

  function automatic logic f_in_range(input logic [SUM_W-1:0] s);
    return s[SUM_W-1] == s[SUM_W-2];
  endfunction

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum  = f_sum(delta_q, dir_down);
    fits = f_in_range(sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      delta_q <= '0;
    end else if (apply) begin
      delta_q <= sum[DELTA_W-1:0];
    end
  end
endmodule

// File: rtl/sde_out_stage.sv
module sde_out_stage
  import sde_pkg::*;
#(
  parameter int PAY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [KIND_W-1:0] load_kind,
  input  logic [PAY_W-1:0]  load_payload,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [KIND_W-1:0] out_kind,
  output logic [PAY_W-1:0]  out_payload,
  output logic              slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_kind    <= '0;
      out_payload <= '0;
    end else if (load) begin
      out_kind    <= load_kind;
      out_payload <= load_payload;
    end
  end
endmodule

// File: rtl/stack_delta_engine.sv
module stack_delta_engine
  import sde_pkg::*;
#(
  parameter int DELTA_W = 8,
  parameter int STEP    = 8,
  parameter int PAY_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [PAY_W-1:0]  in_payload,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [KIND_W-1:0] out_kind,
  output logic [PAY_W-1:0]  out_payload
);
  localparam int EXT_W = PAY_W - DELTA_W;

  function automatic logic [PAY_W-1:0] f_sext(input logic [DELTA_W-1:0] d);
    return {{EXT_W{d[DELTA_W-1]}}, d};
  endfunction

  logic               is_adj, adj_down, is_sp_use;
  logic [DELTA_W-1:0] delta_q;
  logic               adj_fits;
  logic               slot_free;
  logic               need_sync;
  logic               sync_load;
  logic               pass_load;
  logic               adj_accept;
  logic               load_en;
  logic [KIND_W-1:0]  load_kind;
  logic [PAY_W-1:0]   load_payload;

  sde_classify u_classify (
    .kind      (in_kind),
    .is_adj    (is_adj),
    .adj_down  (adj_down),
    .is_sp_use (is_sp_use)
  );

  sde_delta_unit #(.DELTA_W(DELTA_W), .STEP(STEP)) u_delta (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (flush || sync_load),
    .apply    (adj_accept),
    .dir_down (adj_down),
    .delta_q  (delta_q),
    .fits     (adj_fits)
  );

  always_comb begin
    need_sync  = in_valid && ((is_sp_use && (delta_q != '0)) ||
                              (is_adj && !adj_fits));
    in_ready   = !flush && !need_sync && (is_adj || slot_free);
    sync_load  = !flush && need_sync && slot_free;
    adj_accept = in_valid && in_ready && is_adj;
    pass_load  = in_valid && in_ready && !is_adj;
    load_en    = sync_load || pass_load;
    load_kind  = sync_load ? KIND_SYNC : in_kind;
    load_payload = sync_load ? f_sext(delta_q) : in_payload;
  end

  sde_out_stage #(.PAY_W(PAY_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .load         (load_en),
    .load_kind    (load_kind),
    .load_payload (load_payload),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .out_kind     (out_kind),
    .out_payload  (out_payload),
    .slot_free    (slot_free)
  );
endmodule

// File: rtl/stack_delta_engine_chk.sv
module stack_delta_engine_chk
  import sde_pkg::*;
#(
  parameter int DELTA_W = 8,
  parameter int PAY_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               in_valid,
  input logic               in_ready,
  input logic [KIND_W-1:0]  in_kind,
  input logic [PAY_W-1:0]   in_payload,
  input logic               out_valid,
  input logic               out_ready,
  input logic [KIND_W-1:0]  out_kind,
  input logic [PAY_W-1:0]   out_payload,
  input logic [DELTA_W-1:0] delta_q,
  input logic               need_sync,
  input logic               sync_load,
  input logic               pass_load,
  input logic               adj_accept
);
  // input assumption: code 4 is never presented upstream
  a_in_no_sync_code: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_kind != KIND_SYNC);

  // R2
  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n || flush)
    pass_load |=> out_valid && out_kind == $past(in_kind) && out_payload == $past(in_payload));

  // R3
  a_r3_delta_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !adj_accept && !sync_load && !flush |=> $stable(delta_q));

  // R4
  a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
    need_sync |-> !in_ready);

  // R4
  a_r4_sync_clears: assert property (@(posedge clk) disable iff (!rst_n || flush)
    sync_load |=> delta_q == '0 && out_valid && out_kind == KIND_SYNC);

  // R5
  a_r5_zero_before_use: assert property (@(posedge clk) disable iff (!rst_n)
    pass_load && in_kind == KIND_SP_USE |-> delta_q == '0);

  // R7
  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && delta_q == '0);

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n || flush)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_payload));

  // R8
  a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && in_valid &&
    !(in_kind == KIND_ADJ_DOWN || in_kind == KIND_ADJ_UP) |-> !in_ready);
endmodule

bind stack_delta_engine stack_delta_engine_chk #(.DELTA_W(DELTA_W), .PAY_W(PAY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_kind     (in_kind),
  .in_payload  (in_payload),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_kind    (out_kind),
  .out_payload (out_payload),
  .delta_q     (delta_q),
  .need_sync   (need_sync),
  .sync_load   (sync_load),
  .pass_load   (pass_load),
  .adj_accept  (adj_accept)
);

// File: tb/stack_delta_engine_bench.sv
module stack_delta_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_kind = 3'd0;
  logic [15:0] in_payload = 16'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_kind;
  logic [15:0] out_payload;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rmode = 0;       // 0 always ready, 1 pattern, 2 never ready
  int d = 0;           // bench model of the offset
  logic [18:0] got[$];
  logic [18:0] expq[$];

  always #10 clk = ~clk;

  stack_delta_engine u_stack_delta_engine (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_payload(out_payload)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= (rmode == 0) ? 1'b1 : (rmode == 2) ? 1'b0 : ((cyc % 3) != 0);
  end

  always @(negedge clk) begin
    #1;
    if (out_valid && out_ready) got.push_back({out_kind, out_payload});
  end

  localparam int NT = 19;
  localparam logic [18:0] TBL [NT] = '{
    {3'd0, 16'hA001}, {3'd1, 16'h0000}, {3'd1, 16'h0000}, {3'd0, 16'hA002},
    {3'd3, 16'hB001}, {3'd2, 16'h0000}, {3'd5, 16'hA003}, {3'd3, 16'hB002},
    {3'd3, 16'hB003}, {3'd2, 16'h0000}, {3'd2, 16'h0000}, {3'd1, 16'h0000},
    {3'd7, 16'hA004}, {3'd3, 16'hB004}, {3'd0, 16'hA005}, {3'd1, 16'h0000},
    {3'd2, 16'h0000}, {3'd3, 16'hB005}, {3'd6, 16'hA006}
  };

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model(input logic [2:0] k, input logic [15:0] p);
    logic [15:0] dp;
    if (k == 3'd1 || k == 3'd2) begin
      int nd;
      nd = (k == 3'd1) ? d - 8 : d + 8;
      if (nd < -128 || nd > 127) begin
        dp = 16'(d);
        expq.push_back({3'd4, dp});
        d = 0;
        nd = (k == 3'd1) ? -8 : 8;
      end
      d = nd;
    end else if (k == 3'd3) begin
      if (d != 0) begin
        dp = 16'(d);
        expq.push_back({3'd4, dp});
        d = 0;
      end
      expq.push_back({k, p});
    end else begin
      expq.push_back({k, p});
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [15:0] p);
    model(k, p);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_payload = p;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic compare(input string req);
    check(got.size() == expq.size(), {req, " stream length"}, got.size(), expq.size());
    for (int i = 0; i < got.size() && i < expq.size(); i++)
      check(got[i] == expq[i], req, int'(got[i]), int'(expq[i]));
    got.delete();
    expq.delete();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready idle after reset", in_ready, 1);
    send(3'd3, 16'hC001);
    idle(4);
    compare("R1 zero offset after reset");

    // R2 R3 R4 R5 table walk under a back-pressure pattern
    rmode = 1;
    for (int i = 0; i < NT; i++) send(TBL[i][18:16], TBL[i][15:0]);
    idle(10);
    compare("R2 R3 R4 R5 table stream");
    rmode = 0;

    // R6 overflow going down: 17 pushes then explicit use
    for (int i = 0; i < 17; i++) send(3'd1, 16'h0000);
    send(3'd3, 16'hD001);
    idle(4);
    compare("R6 downward overflow");

    // R6 overflow going up: 16 pops then explicit use
    for (int i = 0; i < 16; i++) send(3'd2, 16'h0000);
    send(3'd3, 16'hD002);
    idle(4);
    compare("R6 upward overflow");

    // R4 one-cycle stall while a sync is inserted
    send(3'd1, 16'h0); send(3'd1, 16'h0);
    @(negedge clk);
    in_valid = 1'b1; in_kind = 3'd3; in_payload = 16'hE001;
    #1;
    check(in_ready == 1'b0, "R4 stall during sync insert", in_ready, 0);
    @(negedge clk); #1;
    check(out_valid && out_kind == 3'd4, "R4 sync kind", out_kind, 4);
    check(out_payload == 16'hFFF0, "R4 sync payload", out_payload, 16'hFFF0);
    check(in_ready == 1'b1, "R4 explicit accepted next cycle", in_ready, 1);
    @(negedge clk); #1;
    in_valid = 1'b0;
    check(out_valid && out_kind == 3'd3 && out_payload == 16'hE001,
          "R4 explicit follows sync", out_payload, 16'hE001);
    idle(3);
    got.delete(); expq.delete(); d = 0;

    // R8 back-pressure hold and absorb while blocked
    rmode = 2;
    send(3'd0, 16'hF001);
    @(negedge clk);
    in_valid = 1'b1; in_kind = 3'd5; in_payload = 16'hF002;
    #2;
    check(out_valid && out_payload == 16'hF001, "R8 output loaded", out_payload, 16'hF001);
    check(in_ready == 1'b0, "R8 plain blocked", in_ready, 0);
    @(negedge clk); #2;
    check(out_valid && out_kind == 3'd0 && out_payload == 16'hF001,
          "R8 output stable", out_payload, 16'hF001);
    in_kind = 3'd1; in_payload = 16'h0;
    #1;
    check(in_ready == 1'b1, "R8 adjust absorbed while blocked", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    // R7 flush with a pending output and offset -8
    flush = 1'b1;
    #1;
    check(in_ready == 1'b0, "R7 in_ready low in flush", in_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    #1;
    check(out_valid == 1'b0, "R7 pending output dropped", out_valid, 0);
    rmode = 0;
    got.delete(); expq.delete(); d = 0;
    send(3'd3, 16'hF003);
    idle(4);
    compare("R7 offset cleared by flush");

    summary();
    $finish;
  end
endmodule